// File: doc/BRIEF.md
# Firmware/OS Event Handshake Registers

This block holds two mirrored signalling channels that let platform firmware and the operating system raise events toward each other. In each channel the sender writes a one to a release bit. That write also marks a pending status bit on the receiving side. The receiver acknowledges by writing a one to that status bit, which clears the status and the sender's release bit together. The receiver also owns an enable bit. A level request output is driven while the status is pending and the enable is set.

Channel A goes from firmware to the OS and drives the SCI request. Channel B goes from the OS to firmware and drives the SMI request. Software reaches all six bits through one 8-bit register view. Writes carry a per-bit strobe. Reads are combinational.

Register view, used by the write decode and by reads:
- bit 0: A release
- bit 1: A status
- bit 2: A enable
- bit 3: B release
- bit 4: B status
- bit 5: B enable
- bits 7:6: always read 0

Top module: `evt_handshake_regs`

## Requirements
- R1: A strobed write of 1 to bit 0 (A release) sets bit 0 and bit 1 (A status) at the same clock edge.
- R2: A write of 0, or an unstrobed bit, to a release or status bit leaves that channel's release and status bits unchanged.
- R3: A strobed write of 1 to bit 1 clears both bit 1 and bit 0, provided bit 0 is not being written with 1 in the same write.
- R4: sci_req is 1 exactly when bit 1 and bit 2 both read 1. It is registered, so it reflects the state after the same edge that updates the register.
- R5: A strobed write of 1 to bit 3 (B release) sets bit 3 and bit 4 (B status).
- R6: A strobed write of 1 to bit 4 clears both bit 4 and bit 3, provided bit 3 is not being written with 1 in the same write.
- R7: smi_req is 1 exactly when bit 4 and bit 5 both read 1, with the same registered timing as sci_req.
- R8: If one write puts a 1 on both the release bit and the status bit of a channel, the set wins: both bits end up at 1.
- R9: Enable bits (bits 2 and 5) take the written value when strobed. Clearing an enable drops its request after that edge and leaves the status bit unchanged.
- R10: While rst is high at a clock edge, all six bits and both requests become 0.
- R11: Bits 7:6 of rd_data always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write cycle qualifier |
| wr_strb | input | 8 | Per-bit write strobes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register view |
| sci_req | output | 1 | Request toward the OS (channel A) |
| smi_req | output | 1 | Request toward firmware (channel B) |

## Verification
Some properties are checked inside each channel on every cycle. A release write leaves both bits set. A status clear without a competing set leaves both bits clear. A simultaneous set and clear keeps the status bit set. A cycle with no set and no clear keeps both bits stable. An enable write does not disturb the status bit. A request is never high without its status and enable bits. Only the bench can show the rest: the exact bit positions in the register view, the strobe masking, the value of each request against a model over random write sequences, and that the spare bits read as zero.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int NUM_CH      = 2;
  localparam int BITS_PER_CH = 3;
  localparam int USED_BITS   = NUM_CH * BITS_PER_CH;
  localparam int OFS_REL     = 0;
  localparam int OFS_STS     = 1;
  localparam int OFS_EN      = 2;

  typedef struct packed {
    logic rel_set;
    logic sts_clr;
    logic en_we;
    logic en_d;
  } ch_ctl_t;

  // packed so that bit 0 = rel, bit 1 = sts, bit 2 = en
  typedef struct packed {
    logic en;
    logic sts;
    logic rel;
  } ch_state_t;
endpackage

// File: rtl/hs_wr_decode.sv
module hs_wr_decode #(
  parameter int REG_W = 8
) (
  input  logic                                   wr_en,
  input  logic [REG_W-1:0]                       wr_strb,
  input  logic [REG_W-1:0]                       wr_data,
  output hs_pkg::ch_ctl_t [hs_pkg::NUM_CH-1:0]   ctl
);
  import hs_pkg::*;

  logic [REG_W-1:0] touch;
  logic [REG_W-1:0] one_hit;

  assign touch   = wr_en ? wr_strb : '0;
  assign one_hit = touch & wr_data;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int BASE = ch * BITS_PER_CH;
    assign ctl[ch].rel_set = one_hit[BASE + OFS_REL];
    assign ctl[ch].sts_clr = one_hit[BASE + OFS_STS];
    assign ctl[ch].en_we   = touch[BASE + OFS_EN];
    assign ctl[ch].en_d    = wr_data[BASE + OFS_EN];
  end

  if (REG_W > USED_BITS) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^{touch[REG_W-1:USED_BITS], one_hit[REG_W-1:USED_BITS]};
  end
endmodule

// File: rtl/hs_channel.sv
module hs_channel (
  input  logic              clk,
  input  logic              rst,
  input  hs_pkg::ch_ctl_t   ctl,
  output hs_pkg::ch_state_t state,
  output logic              req
);
  import hs_pkg::*;

  ch_state_t cur, nxt;

  always_comb begin
    nxt = cur;
    if (ctl.en_we) nxt.en = ctl.en_d;
    if (ctl.rel_set) begin
      nxt.rel = 1'b1;
      nxt.sts = 1'b1;
    end else if (ctl.sts_clr) begin
      nxt.rel = 1'b0;
      nxt.sts = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      req <= 1'b0;
    end else begin
      cur <= nxt;
      req <= nxt.sts & nxt.en;
    end
  end

  assign state = cur;

  AST_REL_SETS_PAIR: assert property (@(posedge clk) disable iff (rst)
    ctl.rel_set |=> (cur.rel && cur.sts)); // R1
  AST_STS_CLEARS_PAIR: assert property (@(posedge clk) disable iff (rst)
    (ctl.sts_clr && !ctl.rel_set) |=> (!cur.rel && !cur.sts)); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctl.rel_set && ctl.sts_clr) |=> cur.sts); // R8
  AST_IDLE_PAIR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ctl.rel_set && !ctl.sts_clr) |=> ($stable(cur.rel) && $stable(cur.sts))); // R2
  AST_EN_KEEPS_STS: assert property (@(posedge clk) disable iff (rst)
    (ctl.en_we && !ctl.rel_set && !ctl.sts_clr) |=> (cur.sts == $past(cur.sts))); // R9
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    req |-> (cur.sts && cur.en)); // R4
endmodule

// File: rtl/evt_handshake_regs.sv
module evt_handshake_regs #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_strb,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             sci_req,
  output logic             smi_req
);
  import hs_pkg::*;

  ch_ctl_t   [NUM_CH-1:0] ctl;
  ch_state_t [NUM_CH-1:0] st;
  logic      [NUM_CH-1:0] req_v;

  hs_wr_decode #(.REG_W(REG_W)) i_dec (
    .wr_en  (wr_en),
    .wr_strb(wr_strb),
    .wr_data(wr_data),
    .ctl    (ctl)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    hs_channel i_ch (
      .clk  (clk),
      .rst  (rst),
      .ctl  (ctl[ch]),
      .state(st[ch]),
      .req  (req_v[ch])
    );
  end

  always_comb begin
    rd_data = '0;
    rd_data[USED_BITS-1:0] = st;
  end

  assign sci_req = req_v[0];
  assign smi_req = req_v[1];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !sci_req && !smi_req)); // R10
  AST_SMI_GATED: assert property (@(posedge clk) disable iff (rst)
    smi_req |-> (rd_data[4] && rd_data[5])); // R7
endmodule

// File: tb/test_evt_handshake_regs.sv
`timescale 1ns/1ps
module test_evt_handshake_regs;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [7:0] wr_strb;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       sci_req;
  logic       smi_req;

  int n_checks = 0;
  int n_errors = 0;
  logic [5:0] model;

  always #10 clk = ~clk;

  evt_handshake_regs i_evt_handshake_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_data(rd_data), .sci_req(sci_req), .smi_req(smi_req)
  );

  function automatic logic [5:0] step(logic [5:0] m, logic en, logic [7:0] s, logic [7:0] d);
    logic [5:0] r = m;
    if (en) begin
      for (int c = 0; c < 2; c++) begin
        int b = c * 3;
        if (s[b+2]) r[b+2] = d[b+2];
        if (s[b] && d[b]) begin r[b] = 1'b1; r[b+1] = 1'b1; end
        else if (s[b+1] && d[b+1]) begin r[b] = 1'b0; r[b+1] = 1'b0; end
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " rd"},  rd_data, {2'b00, model});
    check({tag, " sci"}, {7'd0, sci_req}, {7'd0, model[1] & model[2]});
    check({tag, " smi"}, {7'd0, smi_req}, {7'd0, model[4] & model[5]});
  endtask

  task automatic wr(logic [7:0] s, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_strb = s; wr_data = d;
    model = step(model, 1'b1, s, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_strb = '0; wr_data = '0; model = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R10 reset");
    wr(8'h01, 8'h01); check_all("R1 A release");
    wr(8'h03, 8'h00); check_all("R2 write zero");
    wr(8'h02, 8'h00); check_all("R2 strobe no data");
    wr(8'h00, 8'hFF); check_all("R2 no strobe");
    wr(8'h04, 8'h04); check_all("R4 sci on enable");
    check("R4 sci high", {7'd0, sci_req}, 8'd1);
    wr(8'h04, 8'h00); check_all("R9 enable off");
    check("R9 status kept", {7'd0, rd_data[1]}, 8'd1);
    wr(8'h02, 8'h02); check_all("R3 A status clear");
    wr(8'h08, 8'h08); check_all("R5 B release");
    wr(8'h20, 8'h20); check_all("R7 smi on enable");
    check("R7 smi high", {7'd0, smi_req}, 8'd1);
    wr(8'h10, 8'h10); check_all("R6 B status clear");
    wr(8'h1B, 8'h1B); check_all("R8 set wins both");
    check("R8 pair set", rd_data & 8'h1B, 8'h1B);
    wr(8'hC0, 8'hC0); check_all("R11 spare bits");
    check("R11 spare zero", rd_data & 8'hC0, 8'h00);
    wr(8'hFF, 8'hFF);
    do_reset(); check_all("R10 mid reset");

    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] s, d;
      logic en;
      s = 8'($urandom); d = 8'($urandom); en = 1'($urandom);
      @(negedge clk);
      wr_en = en; wr_strb = s; wr_data = d;
      model = step(model, en, s, d);
      @(negedge clk);
      check_all("RAND R1 R3 R5 R6 R8");
    end
    wr_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule